// File: doc/BRIEF.md
# Streaming Data Replicator

The replicator takes a request made of a data word and an unsigned repeat count. It then sends that word on its output stream as many times as the count says. A buffer uses it to send one operand to many processing elements, one beat per receiver, without reading the buffer again for each copy. Both the request side and the output side use a valid/ready handshake. A transfer happens in a cycle where valid and ready are both high. Either side can stall for any length of time and no data is lost.

Requests wait in an in-order queue that holds `QDEPTH` entries. A small state machine takes each request from the head of that queue and turns it into a burst of identical beats. The machine has two states. `ST_IDLE` means no burst is active. `ST_EMIT` means a word is being sent and the remaining count is held in a register. The machine has five named transitions:

- *load* (`ST_IDLE`→`ST_EMIT`): the head request has a nonzero count.
- *discard* (`ST_IDLE`→`ST_IDLE`): the head request has a count of zero and is dropped.
- *beat* (`ST_EMIT`→`ST_EMIT`): a beat that is not the last is accepted and the remaining count goes down by one.
- *chain* (`ST_EMIT`→`ST_EMIT`): the last beat is accepted while a nonzero request waits at the head, and that request is loaded in the same cycle.
- *drain* (`ST_EMIT`→`ST_IDLE`): the last beat is accepted and no nonzero request is waiting.

Top module: `burst_replicator`

## Requirements
- R1: While reset is held, and in the first cycle after it, `out_valid` is 0 and `req_ready` is 1.
- R2: A request is taken when `req_valid` and `req_ready` are both 1. `req_ready` is 0 exactly when `QDEPTH` taken requests are waiting and none of them has been started. No request is taken while it is 0.
- R3: A request with count N (an unsigned `CNT_W`-bit value from 1 to 2^CNT_W−1) produces exactly N output beats, each carrying its data word. Only a cycle with `out_valid` and `out_ready` both high counts as a beat.
- R4: A request of value 15 with count 3 yields exactly three beats, each carrying 15.
- R5: A request with count 0 is taken and produces no output beat.
- R6: Bursts leave in the order their requests were taken. No beat of one burst falls between the beats of another.
- R7: While `out_valid` is 1 and `out_ready` is 0, the next cycle still has `out_valid` at 1, `out_data` unchanged, and no beat counted.
- R8: If the last beat of a burst is accepted while a nonzero request is already waiting, the first beat of that request is offered in the very next cycle.
- R9: The first beat of a request reaching an empty, idle block is offered two cycles after the cycle in which the request is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request queue has a free entry |
| req_data | input | DATA_W | Word to be repeated |
| req_count | input | CNT_W | Number of copies to emit (unsigned) |
| out_valid | output | 1 | Output beat offered |
| out_ready | input | 1 | Downstream takes the beat |
| out_data | output | DATA_W | Repeated word |

## Verification
The bench sends the following patterns and checks the noted behaviour:

- A single 15×3 request with the downstream always ready shows the basic repeat count.
- A zero-count request placed between two live ones shows that a discarded entry leaves no gap and no extra beat.
- A burst of requests sent while the output is held stalled fills the queue. This tells the full condition of the request port apart from the hold behaviour under output backpressure.
- The queue is then drained with an irregular ready pattern, which separates the beat, chain and drain transitions.
- Two queued requests drained with the downstream always ready show whether bursts chain without a bubble.

Every cycle is compared against a behavioural queue model.

// File: rtl/rep_pkg.sv
package rep_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } rep_state_e;

endpackage

// File: rtl/rep_req_queue.sv
module rep_req_queue #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    output logic              push_ready,
    input  logic [DATA_W-1:0] push_data,
    input  logic [CNT_W-1:0]  push_count,
    input  logic              pop,
    output logic              head_valid,
    output logic [DATA_W-1:0] head_data,
    output logic [CNT_W-1:0]  head_count
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
    localparam logic [OCC_W-1:0] FULL_OCC = OCC_W'(DEPTH);

    logic [DATA_W-1:0] data_mem  [DEPTH];
    logic [CNT_W-1:0]  count_mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
    logic [OCC_W-1:0]  occ_q;
    logic              do_push;

    assign push_ready = (occ_q != FULL_OCC);
    assign do_push    = push_valid && push_ready;
    assign head_valid = (occ_q != '0);
    assign head_data  = data_mem[rd_ptr_q];
    assign head_count = count_mem[rd_ptr_q];

    genvar gi;
    generate
        for (gi = 0; gi < DEPTH; gi++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    data_mem[gi]  <= '0;
                    count_mem[gi] <= '0;
                end else if (do_push && (wr_ptr_q == PTR_W'(gi))) begin
                    data_mem[gi]  <= push_data;
                    count_mem[gi] <= push_count;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            occ_q    <= '0;
        end else begin
            if (do_push) begin
                wr_ptr_q <= (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
            end
            if (pop) begin
                rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
            end
            unique case ({do_push, pop})
                2'b10:   occ_q <= occ_q + 1'b1;
                2'b01:   occ_q <= occ_q - 1'b1;
                default: occ_q <= occ_q;
            endcase
        end
    end

    // R2: occupancy never exceeds the queue depth
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= FULL_OCC);

    // R6: the expander pops only an existing entry
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_valid);

    // R2: a lone push grows occupancy by one
    p_push_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_ready && !pop) |=> (occ_q == $past(occ_q) + 1'b1));

endmodule

// File: rtl/rep_expander.sv
module rep_expander
    import rep_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              head_valid,
    input  logic [DATA_W-1:0] head_data,
    input  logic [CNT_W-1:0]  head_count,
    output logic              pop,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    rep_state_e        state_q, state_d;
    logic [CNT_W-1:0]  rem_q, rem_d;
    logic [DATA_W-1:0] word_q, word_d;

    // next state: load, discard, beat, chain, drain
    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        word_d  = word_q;
        pop     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (head_valid) begin
                    pop = 1'b1;
                    if (head_count != '0) begin
                        state_d = ST_EMIT;
                        rem_d   = head_count;
                        word_d  = head_data;
                    end
                end
            end
            ST_EMIT: begin
                if (out_ready) begin
                    if (rem_q == ONE) begin
                        state_d = ST_IDLE;
                        if (head_valid) begin
                            pop = 1'b1;
                            if (head_count != '0) begin
                                state_d = ST_EMIT;
                                rem_d   = head_count;
                                word_d  = head_data;
                            end
                        end
                    end else begin
                        rem_d = rem_q - ONE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rem_q   <= '0;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
            word_q  <= word_d;
        end
    end

    always_comb begin
        out_valid = (state_q == ST_EMIT);
        out_data  = word_q;
    end

    // R7: an offered beat holds while the downstream stalls
    p_hold_beat_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R7: a stall does not consume a repetition
    p_stall_keeps_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> $stable(rem_q));

    // R3: an offered beat always has repetitions left
    p_live_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (rem_q != '0));

    // R3: an accepted non-final beat lowers the count by one
    p_beat_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && (rem_q > ONE)) |=> (rem_q == $past(rem_q) - ONE));

endmodule

// File: rtl/burst_replicator.sv
module burst_replicator #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 8,
    parameter int QDEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [DATA_W-1:0] req_data,
    input  logic [CNT_W-1:0]  req_count,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);

    logic              head_valid;
    logic [DATA_W-1:0] head_data;
    logic [CNT_W-1:0]  head_count;
    logic              pop;

    rep_req_queue #(
        .DATA_W(DATA_W),
        .CNT_W (CNT_W),
        .DEPTH (QDEPTH)
    ) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_valid(req_valid),
        .push_ready(req_ready),
        .push_data (req_data),
        .push_count(req_count),
        .pop       (pop),
        .head_valid(head_valid),
        .head_data (head_data),
        .head_count(head_count)
    );

    rep_expander #(
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) u_expander (
        .clk       (clk),
        .rst_n     (rst_n),
        .head_valid(head_valid),
        .head_data (head_data),
        .head_count(head_count),
        .pop       (pop),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    // R1: nothing is offered in the first cycle after reset
    p_quiet_after_reset_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (!out_valid && req_ready));

endmodule

// File: tb/burst_replicator_bench.sv
module burst_replicator_bench;

    localparam int DATA_W = 16;
    localparam int CNT_W  = 8;
    localparam int QDEPTH = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [DATA_W-1:0] req_data = '0;
    logic [CNT_W-1:0]  req_count = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [DATA_W-1:0] out_data;

    always #2 clk = ~clk;

    burst_replicator #(
        .DATA_W(DATA_W),
        .CNT_W (CNT_W),
        .QDEPTH(QDEPTH)
    ) u_burst_replicator (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_ready(req_ready),
        .req_data (req_data),
        .req_count(req_count),
        .out_valid(out_valid),
        .out_ready(out_ready),
        .out_data (out_data)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // behavioural reference
    int qd[$];
    int qc[$];
    bit m_busy = 0;
    int m_word = 0;
    int m_left = 0;
    int beat_val[$];
    int beat_cyc[$];
    int take_cyc[$];

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    task automatic model_take();
        int d;
        int c;
        d = qd.pop_front();
        c = qc.pop_front();
        if (c != 0) begin
            m_busy = 1;
            m_word = d;
            m_left = c;
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            qd.delete();
            qc.delete();
            m_busy = 0;
            m_left = 0;
        end else begin
            bit acc;
            acc = req_valid && (qd.size() < QDEPTH);
            if (!m_busy) begin
                if (qd.size() > 0) model_take();
            end else if (out_ready) begin
                beat_val.push_back(m_word);
                beat_cyc.push_back(cyc);
                if (m_left == 1) begin
                    m_busy = 0;
                    if (qd.size() > 0) model_take();
                end else begin
                    m_left--;
                end
            end
            if (acc) begin
                qd.push_back(int'(req_data));
                qc.push_back(int'(req_count));
                take_cyc.push_back(cyc);
            end
        end
        cyc++;
    end

    // compare every cycle away from the clock edge
    always @(negedge clk) begin
        if (!rst_n) begin
            chk("R1 reset out_valid", int'(out_valid), 0);
            chk("R1 reset req_ready", int'(req_ready), 1);
        end else begin
            chk("R2 req_ready", int'(req_ready), (qd.size() < QDEPTH) ? 1 : 0);
            chk("R3 R6 R7 out_valid", int'(out_valid), int'(m_busy));
            if (out_valid && m_busy) chk("R3 R6 out_data", int'(out_data), m_word);
        end
    end

    task automatic send(input int d, input int c);
        bit ok;
        req_data  = DATA_W'(d);
        req_count = CNT_W'(c);
        req_valid = 1'b1;
        forever begin
            ok = req_ready;
            @(negedge clk);
            #1;
            if (ok) break;
        end
        req_valid = 1'b0;
    endtask

    task automatic wait_drained();
        while (m_busy || qd.size() > 0) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        #1;
    endtask

    initial begin : watchdog
        #80000;
        fails++;
        $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cyc);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int t0;
        repeat (3) @(negedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 first cycle out_valid", int'(out_valid), 0);

        // R4 and R9: value 15, count 3
        out_ready = 1'b1;
        beat_val.delete(); beat_cyc.delete(); take_cyc.delete();
        send(15, 3);
        wait_drained();
        chk("R4 beat count", beat_val.size(), 3);
        for (int i = 0; i < beat_val.size(); i++) chk("R4 beat value", beat_val[i], 15);
        if (beat_cyc.size() > 0 && take_cyc.size() > 0)
            chk("R9 first beat latency", beat_cyc[0] - take_cyc[0], 2);

        // R5: zero count between live requests
        beat_val.delete(); beat_cyc.delete();
        send(7, 2);
        send(99, 0);
        send(8, 1);
        wait_drained();
        chk("R5 beats with zero request", beat_val.size(), 3);
        if (beat_val.size() == 3) begin
            chk("R5 order a", beat_val[0], 7);
            chk("R5 order b", beat_val[2], 8);
        end

        // R2 and R7: fill the queue while the output is stalled
        out_ready = 1'b0;
        beat_val.delete(); beat_cyc.delete();
        fork
            begin
                for (int k = 0; k < QDEPTH + 2; k++) send(100 + k, k + 1);
            end
            begin
                repeat (14) begin
                    @(negedge clk);
                    #1;
                end
                chk("R2 queue full ready low", int'(req_ready), 0);
                chk("R7 held valid", int'(out_valid), 1);
                chk("R7 held data", int'(out_data), 100);
                for (int j = 0; j < 200; j++) begin
                    out_ready = (j % 3 != 1);
                    @(negedge clk);
                    #1;
                end
                out_ready = 1'b1;
            end
        join
        wait_drained();
        chk("R3 total beats", beat_val.size(), 21);
        begin
            int idx = 0;
            for (int k = 0; k < QDEPTH + 2; k++)
                for (int r = 0; r < k + 1; r++) begin
                    if (idx < beat_val.size()) chk("R6 burst order", beat_val[idx], 100 + k);
                    idx++;
                end
        end

        // R8: chained bursts without a bubble
        out_ready = 1'b0;
        send(40, 2);
        send(41, 2);
        @(negedge clk);
        #1;
        beat_val.delete(); beat_cyc.delete();
        out_ready = 1'b1;
        wait_drained();
        chk("R8 chained beats", beat_val.size(), 4);
        if (beat_cyc.size() == 4) begin
            t0 = beat_cyc[0];
            for (int i = 1; i < 4; i++) chk("R8 no bubble", beat_cyc[i] - t0, i);
            chk("R8 second value", beat_val[2], 41);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule